// File: doc/BRIEF.md
# ETU character transceiver for a smart card data line

The block moves 8-bit characters over one shared, half-duplex smart card I/O line. Every bit lasts one elementary time unit (etu). The etu is a whole number of card clock cycles: a 16-bit divisor, given as a high byte and a low byte, multiplied by an 8-bit prescale count. With a divisor of 31 and a prescale of 12, one etu is 372 clocks. The design runs entirely in the card clock domain, so one `clk` cycle is one card clock.

A direction input picks the mode. In transmit mode the block sends a character when one is offered: a low start bit, eight data bits with the least significant first, and an optional parity bit. It then lets go of the line for a programmable guard time before it accepts the next character. In receive mode the block never drives the line. It synchronises the line, detects a falling start edge and samples each bit at the middle of its etu. Received bytes go into a small FIFO, or into a single holding slot when the FIFO is switched off. Parity and overrun problems are kept in sticky flags, which a status-read strobe clears. A constant identification code is available on a port.

Top module: `sc_char_xcvr`

## Requirements
- R1: One bit period is exactly ({divHi,divLo} × prescale) clock cycles. A product below 2 is treated as 2.
- R2: A character accepted in transmit mode appears in the cycle after the accepting edge. It is a start bit of 0, then data bits 0 to 7 in order, then the parity bit when parityEn=1. lineOe is 1 for every one of these bits.
- R3: When parityEven=1 the transmitted parity bit is the XOR of the eight data bits. When parityEven=0 it is the inverse of that XOR.
- R4: After the last bit, lineOe is 0 for max(guardEtu,1) etus. txReady stays 0 through the guard time and returns to 1 on the following cycle.
- R5: While dirRx=1, lineOe is 0 and txReady is 0. A txValid offered during that time is ignored and is not sent later.
- R6: In receive mode, a falling edge on lineIn starts a character. Bits are sampled at mid-etu with the least significant bit first. The byte then appears on rxData with rxValid=1.
- R7: A start bit that is high again at its mid-etu sample is discarded and produces no character.
- R8: A received parity bit that does not match the parity rule of R3 sets parityErr. The flag stays set until statusRd=1 clears it. The byte is still stored.
- R9: With fifoEn=1, up to 4 received bytes are kept and read out in arrival order. With fifoEn=0, only one byte is kept.
- R10: A byte that arrives while storage is full is dropped and sets the sticky overrun flag, which statusRd clears. The stored bytes are unchanged.
- R11: idCode always reads 70h.
- R12: txReady falls in the cycle after a character is accepted. While rxValid=1 and rxPop=0, rxData holds its value. An rxPop advances to the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divHi | input | 8 | Divisor high byte |
| divLo | input | 8 | Divisor low byte |
| prescale | input | 8 | Prescale multiplier |
| guardEtu | input | 8 | Guard time in etus (0 acts as 1) |
| parityEn | input | 1 | Adds a parity bit to each character |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd parity |
| fifoEn | input | 1 | 1 gives 4-deep receive storage, 0 gives one slot |
| dirRx | input | 1 | 1 selects receive mode (line not driven), 0 selects transmit mode |
| txValid | input | 1 | A character is offered for transmission |
| txData | input | 8 | Character to transmit |
| txReady | output | 1 | The transmitter can accept a character |
| lineIn | input | 1 | Sensed level of the I/O line |
| lineOut | output | 1 | Level driven onto the line |
| lineOe | output | 1 | Drive enable; the line is released when this is 0 |
| rxValid | output | 1 | A received byte is waiting |
| rxData | output | 8 | Oldest received byte |
| rxPop | input | 1 | Removes the oldest received byte |
| statusRd | input | 1 | Clears parityErr and overrun |
| parityErr | output | 1 | Sticky received-parity mismatch |
| overrun | output | 1 | Sticky flag for a byte dropped while storage was full |
| idCode | output | 8 | Constant identification value |

## Verification
The assertions check the properties that must hold on every cycle. The line is never driven in receive mode. txReady is low while the line is driven and falls after an accept. Both sticky flags stay set until statusRd. The head of the receive storage is held while nothing pops it. Other behaviour can only be shown by the bench scenarios, where a cycle-level model of the expected line waveform is compared clock by clock. These scenarios cover the exact etu length, including the 372-clock setting; bit order; the parity sense; the guard release; glitch rejection; FIFO ordering against single-slot storage; and overrun dropping the newest byte.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TXBITS,
    ST_TXGUARD,
    ST_RXBITS
  } xcvrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic driveLine;
    logic rxShift;
    logic rxCheckPar;
    logic rxPush;
  } xcvrStrobes_t;

  function automatic logic parityBit(input logic [7:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction

endpackage

// File: rtl/sc_xcvr_ctrl.sv
module sc_xcvr_ctrl
  import sc_xcvr_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int PRE_W   = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [GUARD_W-1:0] guardEtu,
  input  logic               parityEn,
  input  logic               dirRx,
  input  logic               txValid,
  input  logic               rxFall,
  input  logic               rxBit,
  output logic               txReady,
  output xcvrStrobes_t       st
);

  localparam int ETU_W = DIV_W + PRE_W;
  localparam int IDX_W = 4;

  xcvrState_t          state;
  logic [ETU_W-1:0]    cnt;
  logic [ETU_W-1:0]    etuLen;
  logic [ETU_W-1:0]    etuEff;
  logic [ETU_W-1:0]    etuLast;
  logic [ETU_W-1:0]    midPt;
  logic [IDX_W-1:0]    bitIdx;
  logic [IDX_W-1:0]    lastIdx;
  logic [GUARD_W-1:0]  guardCnt;
  logic [GUARD_W-1:0]  guardLast;
  logic                etuEnd;
  logic                midHit;
  logic                glitch;

  always_comb begin
    etuLen    = ETU_W'(divisor) * ETU_W'(prescale);
    etuEff    = (etuLen < ETU_W'(2)) ? ETU_W'(2) : etuLen;
    etuLast   = etuEff - ETU_W'(1);
    midPt     = etuEff >> 1;
    lastIdx   = parityEn ? IDX_W'(9) : IDX_W'(8);
    guardLast = (guardEtu == '0) ? '0 : guardEtu - GUARD_W'(1);
    etuEnd    = (cnt == etuLast);
    midHit    = (state == ST_RXBITS) && (cnt == midPt);
    glitch    = midHit && (bitIdx == '0) && rxBit;
    txReady   = (state == ST_IDLE) && !dirRx;

    st            = '0;
    st.loadTx     = txReady && txValid;
    st.driveLine  = (state == ST_TXBITS);
    st.shiftTx    = (state == ST_TXBITS) && etuEnd;
    st.rxShift    = midHit && (bitIdx >= IDX_W'(1)) && (bitIdx <= IDX_W'(8));
    st.rxCheckPar = midHit && parityEn && (bitIdx == IDX_W'(9));
    st.rxPush     = midHit && (bitIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      guardCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt      <= '0;
          bitIdx   <= '0;
          guardCnt <= '0;
          if (st.loadTx)           state <= ST_TXBITS;
          else if (dirRx && rxFall) state <= ST_RXBITS;
        end
        ST_TXBITS: begin
          if (dirRx) begin
            state <= ST_IDLE;
          end else if (etuEnd) begin
            cnt <= '0;
            if (bitIdx == lastIdx) begin
              state  <= ST_TXGUARD;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt + ETU_W'(1);
          end
        end
        ST_TXGUARD: begin
          if (dirRx) begin
            state <= ST_IDLE;
          end else if (etuEnd) begin
            cnt <= '0;
            if (guardCnt == guardLast) state <= ST_IDLE;
            else guardCnt <= guardCnt + GUARD_W'(1);
          end else begin
            cnt <= cnt + ETU_W'(1);
          end
        end
        ST_RXBITS: begin
          if (!dirRx || glitch || st.rxPush) begin
            state <= ST_IDLE;
          end else if (etuEnd) begin
            cnt    <= '0;
            bitIdx <= bitIdx + IDX_W'(1);
          end else begin
            cnt <= cnt + ETU_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_xcvr_dp.sv
module sc_xcvr_dp
  import sc_xcvr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  xcvrStrobes_t st,
  input  logic [7:0]   txData,
  input  logic         parityEven,
  input  logic         fifoEn,
  input  logic         dirRx,
  input  logic         lineIn,
  input  logic         rxPop,
  input  logic         statusRd,
  output logic         lineOut,
  output logic         lineOe,
  output logic         rxFall,
  output logic         rxBit,
  output logic         rxValid,
  output logic [7:0]   rxData,
  output logic         parityErr,
  output logic         overrun
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // transmit shifter: {parity, data, start}
  logic [9:0] txSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txSr <= '1;
    else if (st.loadTx) txSr <= {parityBit(txData, parityEven), txData, 1'b0};
    else if (st.shiftTx) txSr <= {1'b1, txSr[9:1]};
  end

  assign lineOut = txSr[0];
  assign lineOe  = st.driveLine && !dirRx;

  // line synchroniser and edge detect
  logic [2:0] syncSr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSr <= '1;
    else       syncSr <= {syncSr[1:0], lineIn};
  end
  assign rxBit  = syncSr[1];
  assign rxFall = syncSr[2] && !syncSr[1];

  // receive shifter
  logic [7:0] rxSr;
  logic [7:0] pushData;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxSr <= '0;
    else if (st.rxShift) rxSr <= {rxBit, rxSr[7:1]};
  end
  assign pushData = st.rxShift ? {rxBit, rxSr[7:1]} : rxSr;

  // receive storage
  logic [7:0]       mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] cap;
  logic             full;
  logic             wrEn;
  logic             doPop;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign cap   = fifoEn ? CNT_W'(FIFO_DEPTH) : CNT_W'(1);
  assign full  = (fill >= cap);
  assign wrEn  = st.rxPush && !full;
  assign doPop = rxPop && (fill != '0);

  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wrEn && (wrPtr == PTR_W'(i))) mem[i] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (wrEn)  wrPtr <= ptrNext(wrPtr);
      if (doPop) rdPtr <= ptrNext(rdPtr);
      fill <= fill + CNT_W'(wrEn) - CNT_W'(doPop);
    end
  end

  assign rxValid = (fill != '0);
  assign rxData  = mem[rdPtr];

  // sticky status, a new event wins over a clear
  logic parSet;
  logic ovrSet;
  assign parSet = st.rxCheckPar && (rxBit != parityBit(rxSr, parityEven));
  assign ovrSet = st.rxPush && full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      parityErr <= (parityErr && !statusRd) || parSet;
      overrun   <= (overrun && !statusRd) || ovrSet;
    end
  end

endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int         FIFO_DEPTH = 4,
  parameter logic [7:0] ID_CODE    = 8'h70
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] divHi,
  input  logic [7:0] divLo,
  input  logic [7:0] prescale,
  input  logic [7:0] guardEtu,
  input  logic       parityEn,
  input  logic       parityEven,
  input  logic       fifoEn,
  input  logic       dirRx,
  input  logic       txValid,
  input  logic [7:0] txData,
  output logic       txReady,
  input  logic       lineIn,
  output logic       lineOut,
  output logic       lineOe,
  output logic       rxValid,
  output logic [7:0] rxData,
  input  logic       rxPop,
  input  logic       statusRd,
  output logic       parityErr,
  output logic       overrun,
  output logic [7:0] idCode
);

  xcvrStrobes_t st;
  logic         rxFall;
  logic         rxBit;

  sc_xcvr_ctrl #(.DIV_W(16), .PRE_W(8), .GUARD_W(8)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .divisor  ({divHi, divLo}),
    .prescale (prescale),
    .guardEtu (guardEtu),
    .parityEn (parityEn),
    .dirRx    (dirRx),
    .txValid  (txValid),
    .rxFall   (rxFall),
    .rxBit    (rxBit),
    .txReady  (txReady),
    .st       (st)
  );

  sc_xcvr_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .txData     (txData),
    .parityEven (parityEven),
    .fifoEn     (fifoEn),
    .dirRx      (dirRx),
    .lineIn     (lineIn),
    .rxPop      (rxPop),
    .statusRd   (statusRd),
    .lineOut    (lineOut),
    .lineOe     (lineOe),
    .rxFall     (rxFall),
    .rxBit      (rxBit),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .parityErr  (parityErr),
    .overrun    (overrun)
  );

  assign idCode = ID_CODE;

endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dirRx,
  input logic       txValid,
  input logic       txReady,
  input logic       lineOe,
  input logic       rxValid,
  input logic       rxPop,
  input logic [7:0] rxData,
  input logic       statusRd,
  input logic       parityErr,
  input logic       overrun
);

  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    dirRx |-> !lineOe) else $error("line driven in receive mode"); // R5

  AST_DRIVE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> !txReady) else $error("ready while driving"); // R4

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady) else $error("still ready after accept"); // R12

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !statusRd) |=> parityErr) else $error("parity flag lost"); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRd) |=> overrun) else $error("overrun flag lost"); // R10

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxPop) |=> (rxValid && $stable(rxData))) else $error("head changed"); // R12

endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dirRx     (dirRx),
  .txValid   (txValid),
  .txReady   (txReady),
  .lineOe    (lineOe),
  .rxValid   (rxValid),
  .rxPop     (rxPop),
  .rxData    (rxData),
  .statusRd  (statusRd),
  .parityErr (parityErr),
  .overrun   (overrun)
);

// File: tb/sc_char_xcvr_tb.sv
module sc_char_xcvr_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divHi = 8'h00, divLo = 8'h04, prescale = 8'h02, guardEtu = 8'h02;
  logic       parityEn = 1'b0, parityEven = 1'b1, fifoEn = 1'b1, dirRx = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txReady, lineOut, lineOe, rxValid, parityErr, overrun;
  logic       lineIn = 1'b1, rxPop = 1'b0, statusRd = 1'b0;
  logic [7:0] rxData, idCode;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sc_char_xcvr u_dut (
    .clk(clk), .rstN(rstN), .divHi(divHi), .divLo(divLo), .prescale(prescale),
    .guardEtu(guardEtu), .parityEn(parityEn), .parityEven(parityEven),
    .fifoEn(fifoEn), .dirRx(dirRx), .txValid(txValid), .txData(txData),
    .txReady(txReady), .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe),
    .rxValid(rxValid), .rxData(rxData), .rxPop(rxPop), .statusRd(statusRd),
    .parityErr(parityErr), .overrun(overrun), .idCode(idCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int etuNow();
    int e = int'({divHi, divLo}) * int'(prescale);
    return (e < 2) ? 2 : e;
  endfunction

  function automatic logic refPar(input logic [7:0] d, input logic even);
    logic x = 1'b0;
    for (int i = 0; i < 8; i++) x = x ^ d[i];
    return even ? x : ~x;
  endfunction

  // cycle-level model of the expected line waveform, compared every clock
  task automatic sendChar(input logic [7:0] d, input string req);
    logic expBits[$];
    int etu = etuNow();
    int g = (guardEtu == 0) ? 1 : int'(guardEtu);
    int errD = 0, errP = 0, errG = 0, errR = 0;
    expBits.push_back(1'b0);
    for (int i = 0; i < 8; i++) expBits.push_back(d[i]);
    if (parityEn) expBits.push_back(refPar(d, parityEven));
    @(negedge clk);
    chk("R12 ready before send", int'(txReady), 1);
    txValid = 1'b1;
    txData = d;
    @(negedge clk);
    txValid = 1'b0;
    for (int b = 0; b < expBits.size(); b++) begin
      for (int c = 0; c < etu; c++) begin
        if (!(b == 0 && c == 0)) @(negedge clk);
        if (lineOe !== 1'b1 || lineOut !== expBits[b]) begin
          if (b == 9) errP++;
          else errD++;
        end
        if (txReady !== 1'b0) errR++;
      end
    end
    for (int c = 0; c < g * etu; c++) begin
      @(negedge clk);
      if (lineOe !== 1'b0) errG++;
      if (txReady !== 1'b0) errR++;
    end
    @(negedge clk);
    chk("R4 ready after guard", int'(txReady), 1);
    chk(req, errD, 0);
    if (parityEn) chk("R3 parity bit", errP, 0);
    chk("R4 guard release", errG, 0);
    chk("R12 busy while sending", errR, 0);
  endtask

  task automatic holdLine(input logic v, input int n);
    @(negedge clk);
    lineIn = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic rxChar(input logic [7:0] d, input bit badPar);
    int etu = etuNow();
    logic p = refPar(d, parityEven);
    if (badPar) p = ~p;
    holdLine(1'b0, etu);
    for (int i = 0; i < 8; i++) holdLine(d[i], etu);
    if (parityEn) holdLine(p, etu);
    holdLine(1'b1, 2 * etu);
  endtask

  task automatic popOne();
    @(negedge clk);
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic clearStatus();
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int errs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R11 id code", int'(idCode), 8'h70);
    chk("R4 ready at reset", int'(txReady), 1);
    chk("R2 released at reset", int'(lineOe), 0);
    chk("R9 empty at reset", int'(rxValid), 0);
    chk("R8 flag clear at reset", int'(parityErr), 0);
    chk("R10 flag clear at reset", int'(overrun), 0);

    // transmit, etu of 8 clocks
    sendChar(8'hA5, "R1 R2 frame A5 no parity");
    parityEn = 1'b1;
    parityEven = 1'b1;
    sendChar(8'h3C, "R2 frame 3C even");
    sendChar(8'h07, "R2 frame 07 even");
    parityEven = 1'b0;
    sendChar(8'h07, "R2 frame 07 odd");
    guardEtu = 8'h00;
    sendChar(8'hFF, "R2 guard zero");
    guardEtu = 8'h03;
    divLo = 8'h03;
    prescale = 8'h01;
    sendChar(8'h81, "R1 etu of 3 clocks");

    // 372-clock etu
    divHi = 8'h00;
    divLo = 8'h1F;
    prescale = 8'h0C;
    guardEtu = 8'h01;
    parityEn = 1'b0;
    sendChar(8'h55, "R1 etu of 372 clocks");

    divLo = 8'h04;
    prescale = 8'h02;
    guardEtu = 8'h02;

    // transmit request in receive mode is ignored
    @(negedge clk);
    dirRx = 1'b1;
    txValid = 1'b1;
    txData = 8'h00;
    errs = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (lineOe !== 1'b0 || txReady !== 1'b0) errs++;
    end
    txValid = 1'b0;
    dirRx = 1'b0;
    chk("R5 no drive in receive mode", errs, 0);
    errs = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (lineOe !== 1'b0 || txReady !== 1'b1) errs++;
    end
    chk("R5 ignored request not sent", errs, 0);

    // receive
    @(negedge clk);
    dirRx = 1'b1;
    parityEn = 1'b1;
    parityEven = 1'b1;
    fifoEn = 1'b1;
    rxChar(8'h96, 1'b0);
    chk("R6 byte valid", int'(rxValid), 1);
    chk("R6 byte value", int'(rxData), 8'h96);
    chk("R8 good parity no flag", int'(parityErr), 0);
    repeat (5) @(negedge clk);
    chk("R12 head held", int'(rxData), 8'h96);
    popOne();
    chk("R12 empty after pop", int'(rxValid), 0);

    rxChar(8'h4E, 1'b1);
    chk("R8 parity error set", int'(parityErr), 1);
    chk("R8 byte still stored", int'(rxData), 8'h4E);
    repeat (20) @(negedge clk);
    chk("R8 flag sticky", int'(parityErr), 1);
    clearStatus();
    chk("R8 flag cleared", int'(parityErr), 0);
    popOne();

    // glitch on start bit
    holdLine(1'b0, 2);
    holdLine(1'b1, 12 * etuNow());
    chk("R7 glitch rejected", int'(rxValid), 0);
    parityEn = 1'b0;
    rxChar(8'h5A, 1'b0);
    chk("R7 next char after glitch", int'(rxData), 8'h5A);
    popOne();

    // FIFO ordering and overrun
    rxChar(8'h11, 1'b0);
    rxChar(8'h22, 1'b0);
    rxChar(8'h33, 1'b0);
    rxChar(8'h44, 1'b0);
    chk("R10 no overrun at four", int'(overrun), 0);
    rxChar(8'h55, 1'b0);
    chk("R10 overrun on fifth", int'(overrun), 1);
    chk("R9 fifo head 1", int'(rxData), 8'h11);
    popOne();
    chk("R9 fifo head 2", int'(rxData), 8'h22);
    popOne();
    chk("R9 fifo head 3", int'(rxData), 8'h33);
    popOne();
    chk("R10 fifo head 4 kept", int'(rxData), 8'h44);
    popOne();
    chk("R10 newest dropped", int'(rxValid), 0);
    clearStatus();
    chk("R10 overrun cleared", int'(overrun), 0);

    // single slot
    fifoEn = 1'b0;
    rxChar(8'hC3, 1'b0);
    rxChar(8'h3C, 1'b0);
    chk("R9 single slot keeps first", int'(rxData), 8'hC3);
    chk("R10 single slot overrun", int'(overrun), 1);
    popOne();
    chk("R9 single slot holds one", int'(rxValid), 0);
    clearStatus();
    chk("R11 id code after traffic", int'(idCode), 8'h70);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule